// File: doc/BRIEF.md
# Rotating-Parity Block Array Controller

This block sits between a single-request host port and an array of NDATA+1 disks. It stripes logical blocks across the disks one block at a time, and the parity slot moves to a different disk on each stripe. For every accepted request it issues a short, strictly serial sequence of single-block disk accesses on one shared disk port. A read that finds its disk healthy touches that one disk and nothing else. A write to a healthy stripe updates parity incrementally by folding the old data and the old parity into the new data.

A failure mask marks unusable disks. With one disk down, reads of blocks on that disk are rebuilt by XOR of every surviving block in the stripe. Writes aimed at the failed disk fold the new data into the parity only. Writes whose parity disk is the failed one store the data and skip the parity. With two or more disks down, each request finishes with an error flag and no disk traffic.

The disk port expects combinational read data: `dsk_rdata` must reflect `dsk_id`/`dsk_stripe` in the same cycle as `dsk_en`. Writes are taken at the clock edge that ends an access cycle.

Top module: `parity_stripe_ctrl`

## Requirements
- R1: Logical block L sits in stripe S = L / NDATA with slot J = L mod NDATA. The parity disk of S is P = S mod (NDATA+1). The data disk is J when J < P and J+1 otherwise. Every access for L drives `dsk_stripe` = S.
- R2: A read whose data disk is healthy makes exactly one access, a read (`dsk_we`=0) of the data disk. `rd_data` in the `done` cycle returns the stored block.
- R3: A write with data and parity disks healthy makes exactly four accesses in this order: read data disk, read parity disk, write new data to the data disk, write parity. The written parity equals old parity XOR old data XOR new data, so the XOR of all disks in the stripe stays zero.
- R4: A read whose data disk is the only failed disk reads every other disk of the stripe once. It never touches the failed disk, and it returns their XOR on `rd_data`.
- R5: A write whose data disk is the only failed disk reads the other NDATA-1 data disks and then writes the parity disk once. The new parity is the new data XOR those blocks, and the failed disk is never accessed.
- R6: A write whose parity disk is the only failed disk makes a single access, a write of the new data to the data disk.
- R7: When two or more bits of `fail_mask` are set at acceptance, the request makes no disk access, and `done` rises with `err` high. `err` is never high outside a `done` cycle.
- R8: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the `done` cycle. `done` lasts one cycle, and requests presented while `busy` is high are ignored.
- R9: `fail_mask` is sampled at acceptance, and no access during that request targets a disk marked failed in the sample.
- R10: After reset `busy`, `done`, `err` and `dsk_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | LBA_W | Logical block number |
| req_wdata | input | BLK_W | Block to write |
| fail_mask | input | NDATA+1 | One bit per disk, 1 = failed |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unrecoverable request, valid with done |
| rd_data | output | BLK_W | Read result, valid with done |
| dsk_en | output | 1 | Disk access this cycle |
| dsk_we | output | 1 | Access is a write |
| dsk_id | output | $clog2(NDATA+1) | Disk selected |
| dsk_stripe | output | LBA_W | Stripe row on the selected disk |
| dsk_wdata | output | BLK_W | Block written to the disk |
| dsk_rdata | input | BLK_W | Block read from the disk, same cycle |

## Verification
A wrong stripe-to-disk decode or a wrong sequencer step shows at the disk port during the request itself. It appears as an access to the wrong disk or stripe, as an access to a failed disk, or as a count or order of accesses that differs from the path chosen at acceptance. A corrupted accumulator shows up in the parity it writes. The damage stays hidden until a later degraded read of that stripe returns a wrong block, or until the array-wide XOR of the stripe is no longer zero. The sweeps therefore recheck every stripe after each phase and do not rely only on the immediate result.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SCAN = 3'd1,
    S_RDAT = 3'd2,
    S_RPAR = 3'd3,
    S_WDAT = 3'd4,
    S_WPAR = 3'd5,
    S_DONE = 3'd6
  } seq_state_e;

endpackage

// File: rtl/stripe_map.sv
// Logical block to (stripe, data disk, parity disk) decode.
module stripe_map #(
  parameter int NDATA = 3,
  parameter int LBA_W = 6,
  parameter int ID_W  = 2
) (
  input  logic [LBA_W-1:0] lba,
  output logic [LBA_W-1:0] stripe,
  output logic [ID_W-1:0]  data_disk,
  output logic [ID_W-1:0]  par_disk
);
  localparam int NDISK = NDATA + 1;
  localparam logic [LBA_W-1:0] DIV_D = LBA_W'(NDATA);
  localparam logic [LBA_W-1:0] DIV_K = LBA_W'(NDISK);

  logic [ID_W-1:0] slot;

  always_comb begin
    stripe    = lba / DIV_D;
    slot      = ID_W'(lba % DIV_D);
    par_disk  = ID_W'(stripe % DIV_K);
    // data slots fill the non-parity disks in ascending order
    data_disk = (slot >= par_disk) ? slot + ID_W'(1) : slot;
  end
endmodule

// File: rtl/xor_accum.sv
// Block-wide XOR accumulator: loads a seed, then folds read data in.
module xor_accum #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             fold,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] acc
);
  logic [BLK_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = load | fold;
    acc_d  = load ? load_val : (acc_q ^ din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/stripe_seq.sv
// Request sequencer: picks a path at acceptance and issues one access per cycle.
module stripe_seq
  import stripe_pkg::*;
#(
  parameter int NDISK = 4,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NDISK-1:0] fail_mask,
  input  logic [ID_W-1:0]  tgt_disk,
  input  logic [ID_W-1:0]  par_disk,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             dsk_en,
  output logic             dsk_we,
  output logic             wr_parity,
  output logic [ID_W-1:0]  dsk_id
);
  localparam logic [ID_W-1:0] LAST = ID_W'(NDISK - 1);

  seq_state_e       st_q, st_d;
  logic [ID_W-1:0]  k_q, k_d;
  logic             wr_q, wr_d;
  logic             err_q, err_d;
  logic [NDISK-1:0] fail_q;
  logic [ID_W:0]    nfail;
  logic             multi;

  always_comb begin
    nfail = '0;
    for (int i = 0; i < NDISK; i++) nfail = nfail + {{ID_W{1'b0}}, fail_mask[i]};
    multi = nfail > (ID_W+1)'(1);
  end

  // next state
  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    wr_d   = wr_q;
    err_d  = err_q;
    accept = (st_q == S_IDLE) && req_valid;
    unique case (st_q)
      S_IDLE: if (accept) begin
        wr_d  = req_write;
        err_d = multi;
        k_d   = '0;
        if (multi)                               st_d = S_DONE;
        else if (fail_mask[tgt_disk])            st_d = S_SCAN;
        else if (req_write && fail_mask[par_disk]) st_d = S_WDAT;
        else                                     st_d = S_RDAT;
      end
      S_SCAN: begin
        if (k_q == LAST) st_d = wr_q ? S_WPAR : S_DONE;
        else             k_d  = k_q + ID_W'(1);
      end
      S_RDAT:  st_d = wr_q ? S_RPAR : S_DONE;
      S_RPAR:  st_d = S_WDAT;
      S_WDAT:  st_d = fail_q[par_disk] ? S_DONE : S_WPAR;
      S_WPAR:  st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // access decode
  always_comb begin
    dsk_en    = 1'b0;
    dsk_we    = 1'b0;
    wr_parity = 1'b0;
    dsk_id    = tgt_disk;
    unique case (st_q)
      S_SCAN: begin
        dsk_id = k_q;
        dsk_en = (k_q != tgt_disk) && !(wr_q && (k_q == par_disk));
      end
      S_RDAT: dsk_en = 1'b1;
      S_RPAR: begin dsk_en = 1'b1; dsk_id = par_disk; end
      S_WDAT: begin dsk_en = 1'b1; dsk_we = 1'b1; end
      S_WPAR: begin dsk_en = 1'b1; dsk_we = 1'b1; wr_parity = 1'b1; dsk_id = par_disk; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      k_q   <= '0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      k_q   <= k_d;
      wr_q  <= wr_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fail_q <= '0;
    else if (accept) fail_q <= fail_mask;
  end

  assign busy = (st_q != S_IDLE);
  assign done = (st_q == S_DONE);
  assign err  = done && err_q;
endmodule

// File: rtl/parity_stripe_ctrl.sv
module parity_stripe_ctrl
  import stripe_pkg::*;
#(
  parameter  int NDATA = 3,
  parameter  int BLK_W = 8,
  parameter  int LBA_W = 6,
  localparam int NDISK = NDATA + 1,
  localparam int ID_W  = $clog2(NDISK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LBA_W-1:0] req_lba,
  input  logic [BLK_W-1:0] req_wdata,
  input  logic [NDISK-1:0] fail_mask,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [BLK_W-1:0] rd_data,
  output logic             dsk_en,
  output logic             dsk_we,
  output logic [ID_W-1:0]  dsk_id,
  output logic [LBA_W-1:0] dsk_stripe,
  output logic [BLK_W-1:0] dsk_wdata,
  input  logic [BLK_W-1:0] dsk_rdata
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             accept;
  logic             wr_parity;
  logic [LBA_W-1:0] lba_q, map_lba;
  logic [BLK_W-1:0] wdata_q;
  logic [ID_W-1:0]  tgt_disk, par_disk;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lba_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      lba_q   <= req_lba;
      wdata_q <= req_wdata;
    end
  end

  assign map_lba = busy ? lba_q : req_lba;

  stripe_map #(.NDATA(NDATA), .LBA_W(LBA_W), .ID_W(ID_W)) u_map (
    .lba       (map_lba),
    .stripe    (dsk_stripe),
    .data_disk (tgt_disk),
    .par_disk  (par_disk)
  );

  stripe_seq #(.NDISK(NDISK), .ID_W(ID_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_write (req_write),
    .fail_mask (fail_mask),
    .tgt_disk  (tgt_disk),
    .par_disk  (par_disk),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .dsk_en    (dsk_en),
    .dsk_we    (dsk_we),
    .wr_parity (wr_parity),
    .dsk_id    (dsk_id)
  );

  xor_accum #(.BLK_W(BLK_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (accept),
    .load_val (req_write ? req_wdata : '0),
    .fold     (dsk_en & ~dsk_we),
    .din      (dsk_rdata),
    .acc      (rd_data)
  );

  assign dsk_wdata = wr_parity ? rd_data : wdata_q;
endmodule

// File: rtl/parity_stripe_ctrl_chk.sv
module parity_stripe_ctrl_chk #(
  parameter int NDISK = 4,
  parameter int ID_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [NDISK-1:0] fail_mask,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             dsk_en,
  input logic [ID_W-1:0]  dsk_id
);
  logic [NDISK-1:0] seen_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_fail <= '0;
    else if (req_valid && !busy)    seen_fail <= fail_mask;
  end

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dsk_en);
  a_r9_skip_failed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dsk_en) |-> !seen_fail[dsk_id]);
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind parity_stripe_ctrl parity_stripe_ctrl_chk #(.NDISK(NDISK), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .fail_mask (fail_mask),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .dsk_en    (dsk_en),
  .dsk_id    (dsk_id)
);

// File: tb/parity_stripe_ctrl_bench.sv
`timescale 1ns/1ps
module parity_stripe_ctrl_bench;
  localparam int ND = 3, NK = 4, BW = 8, LW = 6, NL = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [LW-1:0] req_lba;
  logic [BW-1:0] req_wdata;
  logic [NK-1:0] fail_mask;
  logic busy, done, err, dsk_en, dsk_we;
  logic [BW-1:0] rd_data, dsk_wdata, dsk_rdata;
  logic [1:0] dsk_id;
  logic [LW-1:0] dsk_stripe;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  parity_stripe_ctrl #(.NDATA(ND), .BLK_W(BW), .LBA_W(LW)) u_parity_stripe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_lba(req_lba), .req_wdata(req_wdata), .fail_mask(fail_mask),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .dsk_en(dsk_en), .dsk_we(dsk_we), .dsk_id(dsk_id), .dsk_stripe(dsk_stripe),
    .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata));

  // disk array model
  logic [BW-1:0] mem [NK][64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NK; i++) for (int j = 0; j < 64; j++) mem[i][j] <= '0;
    end else if (dsk_en && dsk_we) mem[dsk_id][dsk_stripe] <= dsk_wdata;
  end
  assign dsk_rdata = mem[dsk_id][dsk_stripe];

  // access log
  int n_acc = 0;
  int log_id [4096];
  int log_we [4096];
  int log_st [4096];
  always @(posedge clk) begin
    if (rst_n && dsk_en && n_acc < 4096) begin
      log_id[n_acc] <= int'(dsk_id);
      log_we[n_acc] <= int'(dsk_we);
      log_st[n_acc] <= int'(dsk_stripe);
      n_acc <= n_acc + 1;
    end
  end

  logic [BW-1:0] model [NL];

  function automatic int f_str(int l); return l / ND; endfunction
  function automatic int f_par(int l); return (l / ND) % NK; endfunction
  function automatic int f_dat(int l);
    int j = l % ND;
    return (j >= f_par(l)) ? j + 1 : j;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // hold=1: keep req_valid high with different content while busy
  task automatic do_req(bit wr, int lba, logic [BW-1:0] wd, bit hold,
                        output logic [BW-1:0] rd, output bit er,
                        output int base, output int cnt);
    int t;
    @(negedge clk);
    base = n_acc;
    req_valid = 1'b1; req_write = wr; req_lba = LW'(lba); req_wdata = wd;
    @(negedge clk);
    if (hold) begin req_lba = LW'(lba + 1); req_wdata = ~wd; end
    else req_valid = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    req_valid = 1'b0;
    chk(done == 1'b1, "R8 done reached", int'(done), 1);
    rd = rd_data; er = err; cnt = n_acc - base;
    @(negedge clk);
  endtask

  function automatic logic [BW-1:0] stripe_xor(int s);
    logic [BW-1:0] x = '0;
    for (int i = 0; i < NK; i++) x ^= mem[i][s];
    return x;
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL R8 watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] rd, wd;
    bit er;
    int base, cnt, d, p, s, hit;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_lba = '0; req_wdata = '0;
    fail_mask = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !dsk_en, "R10 reset outputs low",
        int'({busy, done, err, dsk_en}), 0);

    // phase 1: read-modify-write every block
    for (int l = 0; l < NL; l++) begin
      wd = BW'(l * 37 + 5);
      d = f_dat(l); p = f_par(l); s = f_str(l);
      do_req(1'b1, l, wd, 1'b0, rd, er, base, cnt);
      model[l] = wd;
      chk(cnt == 4, "R3 access count", cnt, 4);
      if (cnt == 4) begin
        chk(log_id[base] == d && log_we[base] == 0, "R3 step1 read data", log_id[base], d);
        chk(log_id[base+1] == p && log_we[base+1] == 0, "R3 step2 read parity", log_id[base+1], p);
        chk(log_id[base+2] == d && log_we[base+2] == 1, "R3 step3 write data", log_id[base+2], d);
        chk(log_id[base+3] == p && log_we[base+3] == 1, "R3 step4 write parity", log_id[base+3], p);
        chk(log_st[base] == s, "R1 stripe", log_st[base], s);
      end
      chk(mem[d][s] == wd, "R3 data stored", int'(mem[d][s]), int'(wd));
      chk(stripe_xor(s) == 0, "R3 stripe parity", int'(stripe_xor(s)), 0);
    end

    // phase 2: healthy reads
    for (int l = 0; l < NL; l++) begin
      do_req(1'b0, l, '0, 1'b0, rd, er, base, cnt);
      chk(cnt == 1, "R2 single access", cnt, 1);
      chk(log_id[base] == f_dat(l) && log_we[base] == 0, "R1 data disk", log_id[base], f_dat(l));
      chk(log_st[base] == f_str(l), "R1 stripe", log_st[base], f_str(l));
      chk(rd == model[l], "R2 read data", int'(rd), int'(model[l]));
    end

    // busy-time request is ignored
    do_req(1'b1, 10, 8'hC3, 1'b1, rd, er, base, cnt);
    model[10] = 8'hC3;
    chk(cnt == 4, "R8 one request only", cnt, 4);
    do_req(1'b0, 11, '0, 1'b0, rd, er, base, cnt);
    chk(rd == model[11], "R8 held request ignored", int'(rd), int'(model[11]));
    do_req(1'b0, 10, '0, 1'b0, rd, er, base, cnt);
    chk(rd == 8'hC3, "R8 first request served", int'(rd), 'hC3);

    // phase 3: disk 1 failed, reads
    fail_mask = 4'b0010;
    for (int l = 0; l < NL; l++) begin
      do_req(1'b0, l, '0, 1'b0, rd, er, base, cnt);
      hit = 0;
      for (int i = 0; i < cnt; i++) if (log_id[base+i] == 1) hit++;
      chk(hit == 0, "R9 failed disk untouched", hit, 0);
      if (f_dat(l) == 1) chk(cnt == NK - 1, "R4 survivor reads", cnt, NK - 1);
      else               chk(cnt == 1, "R2 single access degraded array", cnt, 1);
      chk(rd == model[l], "R4 degraded read data", int'(rd), int'(model[l]));
    end

    // phase 4: disk 1 failed, writes
    for (int l = 0; l < NL; l += 2) begin
      wd = BW'(l * 11 + 90);
      d = f_dat(l); p = f_par(l); s = f_str(l);
      do_req(1'b1, l, wd, 1'b0, rd, er, base, cnt);
      model[l] = wd;
      hit = 0;
      for (int i = 0; i < cnt; i++) if (log_id[base+i] == 1) hit++;
      chk(hit == 0, "R9 failed disk untouched on write", hit, 0);
      if (d == 1) begin
        chk(cnt == ND, "R5 access count", cnt, ND);
        chk(log_id[base+cnt-1] == p && log_we[base+cnt-1] == 1, "R5 parity write last",
            log_id[base+cnt-1], p);
      end else if (p == 1) begin
        chk(cnt == 1, "R6 access count", cnt, 1);
        chk(log_id[base] == d && log_we[base] == 1, "R6 data write", log_id[base], d);
        chk(mem[d][s] == wd, "R6 data stored", int'(mem[d][s]), int'(wd));
      end else begin
        chk(cnt == 4, "R3 bystander failure count", cnt, 4);
      end
    end
    for (int l = 0; l < NL; l++) begin
      do_req(1'b0, l, '0, 1'b0, rd, er, base, cnt);
      chk(rd == model[l], "R5 read after degraded writes", int'(rd), int'(model[l]));
    end

    // phase 5: two failures
    fail_mask = 4'b0101;
    for (int l = 0; l < 6; l++) begin
      do_req(l[0], l, 8'h5A, 1'b0, rd, er, base, cnt);
      chk(er == 1'b1, "R7 error flag", int'(er), 1);
      chk(cnt == 0, "R7 no disk access", cnt, 0);
    end
    fail_mask = '0;
    @(negedge clk);
    chk(!err && !busy, "R7 err clear when idle", int'(err), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule